// File: doc/BRIEF.md
# Direct-Mapped Four-Word-Block Data Cache

This block sits between a processor's load/store port and a slower main memory. It keeps a direct-mapped array of entries. Each entry holds a valid flag, an address tag and a block of four 32-bit words. Every processor access is looked up in the same cycle. A hit on a read returns the selected word at once. Any miss raises the stall output, fetches the whole block from memory one word at a time, installs it, and then replays the access, which now hits.

Writes use a write-through policy. A write hit updates the cached word and also sends the word to memory over a separate word-write port. The processor is held until memory acknowledges that write. A write miss first brings the full block into the cache and then performs the write as a hit, so the three words that were not written come from memory. After reset the block walks through every entry, one per cycle, and clears its valid flag. It stalls the processor for the whole of that walk.

The processor must hold its request, address and write data steady for as long as the stall output is high. An access completes in the cycle where the request is high and the stall output is low.

Top module: `dmc_cache`

## Requirements
- R1: After reset is released, cpu_stall stays high for at least 2^IDX_W cycles while the entries are invalidated, and no memory request is raised in that time. Afterwards the first access to every entry is a miss, so cpu_hit is low in its first cycle.
- R2: Address fields are as follows. The tag is bits [31:IDX_W+4], the index is bits [IDX_W+3:4], the word offset is bits [3:2], and the byte bits [1:0] are ignored. An access with non-zero byte bits behaves exactly like the aligned one, and every memory address the block issues has bits [1:0] at zero.
- R3: A read whose index holds a valid entry with a matching tag raises cpu_hit and keeps cpu_stall low in that same cycle. cpu_rdata is then the stored word chosen by the word offset.
- R4: On a read miss, mem_rd_req is raised for four word reads of the block at word offsets 0, 1, 2 and 3 in that order. Each read keeps its request and address steady until mem_rd_ack. After the fourth acknowledge the access replays and completes with cpu_hit high and the freshly fetched word on cpu_rdata.
- R5: On a write hit, mem_wr_req is raised with the word-aligned address and cpu_wdata, held until mem_wr_ack. cpu_stall stays high until the acknowledge cycle. The addressed cached word takes the new value and the other three words of the block are unchanged.
- R6: On a write miss, the whole block is first fetched as in R4, and then the write is done as in R5. A later read returns the written word at its offset and the memory contents at the other three offsets.
- R7: An access whose index holds a different tag replaces that entry: it misses, it fetches the new block, and a later access to the old tag misses again.
- R8: mem_rd_req and mem_wr_req are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid when a read completes |
| cpu_hit | output | 1 | Lookup hit on the current request |
| cpu_stall | output | 1 | Processor must hold its request |
| mem_rd_req | output | 1 | Word read request to memory |
| mem_rd_addr | output | 32 | Word-aligned read address |
| mem_rd_ack | input | 1 | Read data accepted this cycle |
| mem_rd_data | input | 32 | Read data from memory |
| mem_wr_req | output | 1 | Write-through word request to memory |
| mem_wr_addr | output | 32 | Word-aligned write address |
| mem_wr_data | output | 32 | Write-through data |
| mem_wr_ack | input | 1 | Write accepted this cycle |

## Verification
Some properties are checked by the assertions on every cycle. A read hit never stalls. Read and write-through requests hold until acknowledged, and a read also holds its address until then. Fill addresses step through the block in ascending word order. The cycle after a completed fill always hits, and a write-through request only appears while the lookup hits. Other behaviour only shows up in the bench scenarios:
- the length of the invalidation walk after reset;
- that the data returned is right across every index and offset;
- that a conflicting tag really evicts the old block;
- that a write miss merges the new word with the three fetched words;
- that written words reach memory and come back after eviction.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [1:0] {
    ST_SWEEP = 2'd0,
    ST_IDLE  = 2'd1,
    ST_FILL  = 2'd2,
    ST_WRITE = 2'd3
  } dmc_state_e;
endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
  parameter int IDX_W = 12,
  parameter int TAG_W = 16
) (
  input  logic             clk,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic             set_en,
  output logic             lk_hit
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];

  // Arrays carry no reset; the controller's sweep clears the valid flags.
  always_ff @(posedge clk) begin
    if (clr_en) begin
      valid_q[clr_idx] <= 1'b0;
    end else if (set_en) begin
      valid_q[lk_idx] <= 1'b1;
      tag_q[lk_idx]   <= lk_tag;
    end
  end

  always_comb begin
    lk_hit = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
  end
endmodule

// File: rtl/dmc_data_banks.sv
module dmc_data_banks #(
  parameter int IDX_W  = 12,
  parameter int WORD_W = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [WORD_W-1:0] rd_word,
  output logic [DATA_W-1:0] rd_data
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int WORDS   = 1 << WORD_W;

  logic [DATA_W-1:0] bank_out [WORDS];

  // One storage bank per word position of the block.
  for (genvar b = 0; b < WORDS; b++) begin : g_bank
    logic [DATA_W-1:0] mem [ENTRIES];
    logic              bank_we;

    always_comb begin
      bank_we = wr_en && (wr_word == WORD_W'(b));
    end

    always_ff @(posedge clk) begin
      if (bank_we) begin
        mem[idx] <= wr_data;
      end
    end

    always_comb begin
      bank_out[b] = mem[idx];
    end
  end

  // Block-offset multiplexer
  always_comb begin
    rd_data = bank_out[rd_word];
  end
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
  import dmc_pkg::*;
#(
  parameter int IDX_W  = 12,
  parameter int WORD_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic              lk_hit,
  input  logic              mem_rd_ack,
  input  logic              mem_wr_ack,
  output logic              cpu_stall,
  output logic              lookup_ok,
  output logic              clr_en,
  output logic [IDX_W-1:0]  clr_idx,
  output logic              fill_wr,
  output logic              fill_done,
  output logic              fill_active,
  output logic [WORD_W-1:0] fill_word,
  output logic              thru_wr,
  output logic              mem_rd_req,
  output logic              mem_wr_req
);
  dmc_state_e        state_q, state_d;
  logic [IDX_W-1:0]  sweep_q, sweep_d;
  logic              sweep_en;
  logic [WORD_W-1:0] word_q, word_d;
  logic              word_en;

  always_comb begin
    state_d     = state_q;
    sweep_d     = sweep_q + 1'b1;
    sweep_en    = 1'b0;
    word_d      = word_q + 1'b1;
    word_en     = 1'b0;
    cpu_stall   = 1'b0;
    lookup_ok   = 1'b0;
    clr_en      = 1'b0;
    fill_wr     = 1'b0;
    fill_done   = 1'b0;
    fill_active = 1'b0;
    thru_wr     = 1'b0;
    mem_rd_req  = 1'b0;
    mem_wr_req  = 1'b0;
    case (state_q)
      ST_SWEEP: begin
        cpu_stall = 1'b1;
        clr_en    = 1'b1;
        sweep_en  = 1'b1;
        if (sweep_q == '1) begin
          state_d = ST_IDLE;
        end
      end
      ST_IDLE: begin
        lookup_ok = 1'b1;
        if (cpu_req) begin
          if (!lk_hit) begin
            cpu_stall = 1'b1;
            state_d   = ST_FILL;
            word_en   = 1'b1;
            word_d    = '0;
          end else if (cpu_we) begin
            cpu_stall = 1'b1;
            state_d   = ST_WRITE;
          end
        end
      end
      ST_FILL: begin
        cpu_stall   = 1'b1;
        fill_active = 1'b1;
        mem_rd_req  = 1'b1;
        if (mem_rd_ack) begin
          fill_wr = 1'b1;
          word_en = 1'b1;
          if (word_q == '1) begin
            fill_done = 1'b1;
            state_d   = ST_IDLE;
          end
        end
      end
      ST_WRITE: begin
        lookup_ok  = 1'b1;
        mem_wr_req = 1'b1;
        cpu_stall  = !mem_wr_ack;
        if (mem_wr_ack) begin
          thru_wr = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_SWEEP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_SWEEP;
      sweep_q <= '0;
      word_q  <= '0;
    end else begin
      state_q <= state_d;
      if (sweep_en) sweep_q <= sweep_d;
      if (word_en)  word_q  <= word_d;
    end
  end

  always_comb begin
    clr_idx   = sweep_q;
    fill_word = word_q;
  end

  assert_wr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_req && !mem_wr_ack) |=> mem_wr_req)
    else $error("write-through request dropped before ack");
endmodule

// File: rtl/dmc_cache.sv
module dmc_cache #(
  parameter int IDX_W  = 12,
  parameter int WORD_W = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_req,
  input  logic        cpu_we,
  input  logic [31:0] cpu_addr,
  input  logic [31:0] cpu_wdata,
  output logic [31:0] cpu_rdata,
  output logic        cpu_hit,
  output logic        cpu_stall,
  output logic        mem_rd_req,
  output logic [31:0] mem_rd_addr,
  input  logic        mem_rd_ack,
  input  logic [31:0] mem_rd_data,
  output logic        mem_wr_req,
  output logic [31:0] mem_wr_addr,
  output logic [31:0] mem_wr_data,
  input  logic        mem_wr_ack
);
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int BYTE_W = $clog2(DATA_W / 8);
  localparam int OFF_LO = BYTE_W;
  localparam int IDX_LO = BYTE_W + WORD_W;
  localparam int TAG_LO = IDX_LO + IDX_W;
  localparam int TAG_W  = ADDR_W - TAG_LO;

  // Reset: asynchronous assertion, synchronous release
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  // Address fields
  logic [TAG_W-1:0]  a_tag;
  logic [IDX_W-1:0]  a_idx;
  logic [WORD_W-1:0] a_word;
  logic              unused_byte_bits;
  always_comb begin
    a_tag            = cpu_addr[ADDR_W-1:TAG_LO];
    a_idx            = cpu_addr[TAG_LO-1:IDX_LO];
    a_word           = cpu_addr[IDX_LO-1:OFF_LO];
    unused_byte_bits = ^cpu_addr[BYTE_W-1:0];
  end

  logic              lk_hit, lookup_ok;
  logic              clr_en, fill_wr, fill_done, fill_active, thru_wr;
  logic [IDX_W-1:0]  clr_idx;
  logic [WORD_W-1:0] fill_word;

  dmc_ctrl #(.IDX_W(IDX_W), .WORD_W(WORD_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .cpu_req    (cpu_req),
    .cpu_we     (cpu_we),
    .lk_hit     (lk_hit),
    .mem_rd_ack (mem_rd_ack),
    .mem_wr_ack (mem_wr_ack),
    .cpu_stall  (cpu_stall),
    .lookup_ok  (lookup_ok),
    .clr_en     (clr_en),
    .clr_idx    (clr_idx),
    .fill_wr    (fill_wr),
    .fill_done  (fill_done),
    .fill_active(fill_active),
    .fill_word  (fill_word),
    .thru_wr    (thru_wr),
    .mem_rd_req (mem_rd_req),
    .mem_wr_req (mem_wr_req)
  );

  dmc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk    (clk),
    .lk_idx (a_idx),
    .lk_tag (a_tag),
    .clr_en (clr_en),
    .clr_idx(clr_idx),
    .set_en (fill_done),
    .lk_hit (lk_hit)
  );

  logic              dat_we;
  logic [WORD_W-1:0] dat_word;
  logic [DATA_W-1:0] dat_wdata;
  always_comb begin
    dat_we    = fill_wr || thru_wr;
    dat_word  = fill_active ? fill_word : a_word;
    dat_wdata = fill_active ? mem_rd_data : cpu_wdata;
  end

  dmc_data_banks #(.IDX_W(IDX_W), .WORD_W(WORD_W), .DATA_W(DATA_W)) u_data (
    .clk    (clk),
    .wr_en  (dat_we),
    .idx    (a_idx),
    .wr_word(dat_word),
    .wr_data(dat_wdata),
    .rd_word(a_word),
    .rd_data(cpu_rdata)
  );

  always_comb begin
    cpu_hit     = cpu_req && lookup_ok && lk_hit;
    mem_rd_addr = {a_tag, a_idx, fill_word, {BYTE_W{1'b0}}};
    mem_wr_addr = {cpu_addr[ADDR_W-1:BYTE_W], {BYTE_W{1'b0}}};
    mem_wr_data = cpu_wdata;
  end

  logic [WORD_W-1:0] rd_addr_word;
  always_comb rd_addr_word = mem_rd_addr[IDX_LO-1:OFF_LO];

  assert_read_hit_R3: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (cpu_req && !cpu_we && cpu_hit) |-> !cpu_stall)
    else $error("read hit stalled");

  assert_rd_hold_R4: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (mem_rd_req && !mem_rd_ack) |=> (mem_rd_req && $stable(mem_rd_addr)))
    else $error("fill request changed before ack");

  assert_fill_order_R4: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (mem_rd_req && mem_rd_ack && (rd_addr_word != '1))
      |=> (mem_rd_req && (rd_addr_word == WORD_W'($past(rd_addr_word) + 1'b1))))
    else $error("fill words out of order");

  assert_fill_replay_R4: assert property (@(posedge clk) disable iff (!rst_sync_q)
    ($past(fill_done) && cpu_req) |-> cpu_hit)
    else $error("access after fill did not hit");

  assert_thru_on_hit_R5: assert property (@(posedge clk) disable iff (!rst_sync_q)
    mem_wr_req |-> cpu_hit)
    else $error("write-through without a hit");
endmodule

// File: tb/dmc_cache_tb.sv
`timescale 1ns/100ps
module dmc_cache_tb;
  localparam int IDX_W   = 4;
  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_SH  = IDX_W + 4;

  logic        clk, rst_n;
  logic        cpu_req, cpu_we;
  logic [31:0] cpu_addr, cpu_wdata, cpu_rdata;
  logic        cpu_hit, cpu_stall;
  logic        mem_rd_req, mem_rd_ack, mem_wr_req, mem_wr_ack;
  logic [31:0] mem_rd_addr, mem_rd_data, mem_wr_addr, mem_wr_data;

  dmc_cache #(.IDX_W(IDX_W), .WORD_W(2)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_hit(cpu_hit), .cpu_stall(cpu_stall),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_ack(mem_rd_ack),
    .mem_rd_data(mem_rd_data), .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .mem_wr_ack(mem_wr_ack)
  );

  initial begin
    clk = 1'b0;
    forever #2.5 clk = ~clk;
  end

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [31:0] wmem [logic [29:0]];
  logic [31:0] rd_log [64];
  int rd_n = 0, wr_n = 0, rd_lat = 0, wr_lat = 0, rd_wait = 0, wr_wait = 0;
  logic [31:0] wlog_a, wlog_d;
  bit overlap = 0;
  logic [31:0] r_data;
  bit f_hit, l_hit;
  int ncyc;

  function automatic logic [31:0] mk(int t, int i, int o);
    return (32'(t) << TAG_SH) | (32'(i) << 4) | (32'(o) << 2);
  endfunction

  function automatic logic [31:0] model(logic [31:0] a);
    if (wmem.exists(a[31:2])) return wmem[a[31:2]];
    return ({a[31:2], 2'b00} * 32'h0100_0193) ^ 32'h5A5A_0F0F;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // Memory read responder
  initial begin
    mem_rd_ack = 1'b0;
    mem_rd_data = '0;
    forever begin
      @(negedge clk);
      if (mem_rd_req && mem_wr_req) overlap = 1;
      if (mem_rd_req && !mem_rd_ack) begin
        if (rd_wait >= rd_lat) begin
          mem_rd_ack  = 1'b1;
          mem_rd_data = model(mem_rd_addr);
          rd_log[rd_n[5:0]] = mem_rd_addr;
          rd_n++;
          rd_wait = 0;
        end else rd_wait++;
      end else mem_rd_ack = 1'b0;
    end
  end

  // Memory write responder
  initial begin
    mem_wr_ack = 1'b0;
    forever begin
      @(negedge clk);
      if (mem_wr_req && !mem_wr_ack) begin
        if (wr_wait >= wr_lat) begin
          mem_wr_ack = 1'b1;
          wlog_a = mem_wr_addr;
          wlog_d = mem_wr_data;
          wmem[mem_wr_addr[31:2]] = mem_wr_data;
          wr_n++;
          wr_wait = 0;
        end else wr_wait++;
      end else mem_wr_ack = 1'b0;
    end
  end

  task automatic acc(input bit we, input logic [31:0] a, input logic [31:0] wd);
    bit done;
    rd_n = 0;
    wr_n = 0;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    ncyc = 0;
    done = 0;
    while (!done) begin
      #2;
      ncyc++;
      if (ncyc == 1) f_hit = cpu_hit;
      if (!cpu_stall) begin
        done = 1;
        l_hit = cpu_hit;
        r_data = cpu_rdata;
      end else if (ncyc > 2000) begin
        done = 1;
        chk(0, "R4", "access never completed", 0, 0);
      end else @(negedge clk);
    end
    @(negedge clk);
    cpu_req = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired act=0 exp=1");
    summary();
  end

  initial begin
    int sc;
    bit quiet;
    logic [31:0] a, wd;
    rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: invalidation sweep
    sc = 0; quiet = 1;
    for (int k = 0; k < 200; k++) begin
      #2;
      if (mem_rd_req || mem_wr_req) quiet = 0;
      if (!cpu_stall) break;
      sc++;
      @(negedge clk);
    end
    chk(sc >= ENTRIES && sc <= ENTRIES + 3, "R1", "sweep stall cycles", 32'(sc), 32'(ENTRIES));
    chk(quiet, "R1", "no memory request during sweep", 32'(quiet), 1);

    // R1/R3/R4: all indices and offsets, tag 5
    for (int i = 0; i < ENTRIES; i++) begin
      rd_lat = i % 3;
      for (int o = 0; o < 4; o++) begin
        a = mk(5, i, o);
        acc(0, a, 0);
        chk(r_data == model(a), "R3", "read data", r_data, model(a));
        if (o == 0) begin
          chk(!f_hit, "R1", "first access misses", 32'(f_hit), 0);
          chk(rd_n == 4, "R4", "fill read count", 32'(rd_n), 4);
          for (int k = 0; k < 4; k++)
            chk(rd_log[k] == mk(5, i, k), "R4", "fill address order", rd_log[k], mk(5, i, k));
          chk(l_hit, "R4", "replay hits", 32'(l_hit), 1);
        end else begin
          chk(f_hit && ncyc == 1, "R3", "hit without stall", 32'(ncyc), 1);
          chk(rd_n == 0, "R3", "no fill on hit", 32'(rd_n), 0);
        end
      end
      // R2: byte bits ignored on read
      a = mk(5, i, i % 4);
      acc(0, a | 32'(i % 4), 0);
      chk(f_hit && ncyc == 1 && r_data == model(a), "R2", "byte bits ignored on read", r_data, model(a));
    end

    // R7: conflicting tag evicts
    for (int i = 0; i < ENTRIES; i++) begin
      a = mk(9, i, i % 4);
      acc(0, a, 0);
      chk(!f_hit && rd_n == 4 && r_data == model(a), "R7", "new tag fetched", r_data, model(a));
      acc(0, mk(5, i, 0), 0);
      chk(!f_hit && rd_n == 4, "R7", "old tag misses again", 32'(f_hit), 0);
      chk(r_data == model(mk(5, i, 0)), "R7", "old tag data", r_data, model(mk(5, i, 0)));
    end

    // R5/R2: write hits with byte bits set
    for (int i = 0; i < ENTRIES; i++) begin
      wr_lat = i % 2;
      wd = 32'hC0DE_0000 | 32'(i);
      a = mk(5, i, i % 4);
      acc(1, a | 32'(i & 3), wd);
      chk(f_hit && rd_n == 0, "R5", "write hit no fill", 32'(rd_n), 0);
      chk(wr_n == 1 && wlog_a == a, "R2", "write-through address aligned", wlog_a, a);
      chk(wlog_d == wd, "R5", "write-through data", wlog_d, wd);
      for (int o = 0; o < 4; o++) begin
        acc(0, mk(5, i, o), 0);
        if (o == i % 4)
          chk(f_hit && r_data == wd, "R5", "updated word", r_data, wd);
        else
          chk(f_hit && r_data == model(mk(5, i, o)), "R5", "neighbour unchanged", r_data, model(mk(5, i, o)));
      end
    end

    // R6: write misses, tag 12
    for (int i = 0; i < ENTRIES; i++) begin
      rd_lat = (i + 1) % 3;
      wd = 32'hBEEF_0000 | 32'(i);
      acc(1, mk(12, i, (i + 1) % 4), wd);
      chk(!f_hit && rd_n == 4, "R6", "write miss fills", 32'(rd_n), 4);
      chk(wr_n == 1 && wlog_d == wd, "R6", "write after fill", wlog_d, wd);
      for (int o = 0; o < 4; o++) begin
        acc(0, mk(12, i, o), 0);
        if (o == (i + 1) % 4)
          chk(f_hit && r_data == wd, "R6", "merged word", r_data, wd);
        else
          chk(f_hit && r_data == model(mk(12, i, o)), "R6", "fetched word", r_data, model(mk(12, i, o)));
      end
      // R5: the earlier write reached memory
      acc(0, mk(5, i, i % 4), 0);
      chk(!f_hit && r_data == (32'hC0DE_0000 | 32'(i)), "R5", "write-through survives eviction",
          r_data, 32'hC0DE_0000 | 32'(i));
    end

    chk(!overlap, "R8", "read and write requests overlapped", 32'(overlap), 0);
    summary();
  end
endmodule